// File: doc/BRIEF.md
# Multi-Channel DMA Transfer Controller

This block is the control and status core of a small DMA engine with a parameterized number of channels. Each channel owns a source address, a destination address, a transfer counter and a control word. One shared word holds a master enable and two sticky fault flags: an NMI flag and an address-error flag. Software programs the registers through a simple single-cycle write port and reads them back through a combinational read port on the same address.

A channel requests transfers either on its own, as soon as it is enabled, or from an active-low external request pin sampled by level or by falling edge. The controller issues one data unit per bus cycle on a request/acknowledge master port. The cycle stays open until the bus acknowledges it. Then the counter decrements, the addresses step by the unit size when stepping is selected, and the transfer-end flag rises when the counter reaches zero.

Stopping is precise. An NMI, a cleared master enable or an address fault never cuts a bus cycle short. Each lets the open cycle finish and then blocks new ones. After an NMI the counter and addresses of the interrupted channel still describe the remaining work.

Top module: `dma_ctrl`

## Requirements
- R1: After reset every channel register and the shared word read 0 and `bus_req` is low. Register map: channel c word i sits at address 4*c+i, with i=0 source, i=1 destination, i=2 count and i=3 control. The shared word sits at address 8.
- R2: A channel starts a bus cycle only while both the master enable (shared bit 0) and its own enable (control bit 0) are 1. Either bit may be set first.
- R3: Each acknowledged cycle decrements the count by 1. It advances the source when control bit 2 is 1, and the destination when control bit 3 is 1, by 1, 2 or 4 bytes for size field bits 5:4 = 0, 1 or 2. At count 0 it sets the transfer-end flag (control bit 1) and leaves the enable at 1.
- R4: A high `nmi` sets the NMI flag (shared bit 1) even with no channel active. While it is set no bus cycle starts. Writing 0 to that bit clears it, and writing 1 leaves it unchanged.
- R5: An NMI during a transfer lets the open cycle finish and then stops the channel. The enable stays 1 and the end flag stays 0. The count holds the transfers remaining, and the addresses hold the next source and destination.
- R6: If the NMI flag is set before a channel starts, the count keeps its programmed value.
- R7: In single-address mode (control bit 6) a source whose top 4 bits are 0xF is internal. Such a source sets the address-error flag (shared bit 2) and no channel starts a cycle until the flag is cleared by writing 0.
- R8: A source address, or in dual-address mode a destination address, that is not aligned to the unit size, or a size code of 3, sets the address-error flag without starting a cycle.
- R9: Clearing the master enable during a cycle keeps `bus_req` high until `bus_ack`. That transfer completes and no further cycle starts.
- R10: With external request (control bit 7) and edge mode (control bit 8 = 1), each falling edge of `dreq_n` allows exactly one transfer.
- R11: With external request in level mode (control bit 8 = 0), transfers run while `dreq_n` is low and none start while it is high.
- R12: Writes to a channel's source, destination or count are ignored while its enable bit is 1.
- R13: When several channels are ready, the lowest-numbered one wins. `bus_req` and `bus_ch` hold until the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi | input | 1 | Non-maskable interrupt, sets the NMI flag while high |
| dreq_n | input | NCH | Active-low external request, one per channel |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | CHW+3 | Register address for write and read |
| reg_wdata | input | AW | Register write data |
| reg_rdata | output | AW | Register read data for `reg_addr` |
| bus_req | output | 1 | Bus cycle request, held until acknowledged |
| bus_ch | output | CHW | Channel owning the current cycle |
| bus_src | output | AW | Source address (the only address in single mode) |
| bus_dst | output | AW | Destination address |
| bus_size | output | 2 | Unit size code: 0 byte, 1 half, 2 word |
| bus_single | output | 1 | Cycle is single-address |
| bus_ack | input | 1 | Bus acknowledge, completes the open cycle |

## Verification
The hardest situation to reach is an NMI that lands in the middle of a transfer. To be useful it must arrive after some cycles have completed and while another cycle is still waiting for its acknowledge. The bench slows the acknowledge to several cycles and waits until its own responder has granted two transfers. It then pulses `nmi`, counts how many acknowledges were actually granted, and checks that the count, both addresses and the enable/end flags agree with that number. A second, smaller case is the master enable being cleared while a long bus cycle is open, which uses the same slowed responder.

// File: rtl/dma_ctrl.sv
module dma_ctrl #(
  parameter int NCH = 2,
  parameter int AW = 16,
  parameter logic [3:0] IPAGE = 4'hF,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int RAW = CHW + 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           nmi,
  input  logic [NCH-1:0] dreq_n,
  input  logic           reg_we,
  input  logic [RAW-1:0] reg_addr,
  input  logic [AW-1:0]  reg_wdata,
  output logic [AW-1:0]  reg_rdata,
  output logic           bus_req,
  output logic [CHW-1:0] bus_ch,
  output logic [AW-1:0]  bus_src,
  output logic [AW-1:0]  bus_dst,
  output logic [1:0]     bus_size,
  output logic           bus_single,
  input  logic           bus_ack
);
  // control word: 0 en, 1 end, 2 src step, 3 dst step, 5:4 size, 6 single, 7 ext, 8 edge
  logic [AW-1:0]  src [NCH];
  logic [AW-1:0]  dst [NCH];
  logic [AW-1:0]  cnt [NCH];
  logic [8:0]     ctl [NCH];
  logic [NCH-1:0] pend, dreq_q;
  logic           dme, nmif, aef, busy, any, bad;
  logic [CHW-1:0] act, pick;
  logic [AW-1:0]  step, pstep;

  wire [CHW-1:0] wch  = reg_addr[RAW-2:2];
  wire [1:0]     widx = reg_addr[1:0];
  wire           wop  = reg_addr[RAW-1];

  always_comb begin
    any  = 1'b0;
    pick = '0;
    for (int c = NCH - 1; c >= 0; c--) begin
      if (ctl[c][0] && !ctl[c][1] && cnt[c] != '0 &&
          (!ctl[c][7] || (ctl[c][8] ? pend[c] : !dreq_n[c]))) begin
        any  = 1'b1;
        pick = CHW'(c);
      end
    end
  end

  always_comb begin
    pstep = AW'(1) << ctl[pick][5:4];
    bad = (ctl[pick][5:4] == 2'd3)
       || ((src[pick] & (pstep - 1'b1)) != '0)
       || (!ctl[pick][6] && ((dst[pick] & (pstep - 1'b1)) != '0))
       || (ctl[pick][6] && src[pick][AW-1 -: 4] == IPAGE);
  end

  assign step       = AW'(1) << ctl[act][5:4];
  assign bus_req    = busy;
  assign bus_ch     = act;
  assign bus_src    = src[act];
  assign bus_dst    = dst[act];
  assign bus_size   = ctl[act][5:4];
  assign bus_single = ctl[act][6];

  wire go = !busy && dme && !nmif && !aef && any;

  always_comb begin
    if (wop) reg_rdata = AW'({aef, nmif, dme});
    else begin
      case (widx)
        2'd0:    reg_rdata = src[wch];
        2'd1:    reg_rdata = dst[wch];
        2'd2:    reg_rdata = cnt[wch];
        default: reg_rdata = AW'(ctl[wch]);
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        src[c] <= '0;
        dst[c] <= '0;
        cnt[c] <= '0;
        ctl[c] <= '0;
      end
      pend   <= '0;
      dreq_q <= '1;
      dme    <= 1'b0;
      nmif   <= 1'b0;
      aef    <= 1'b0;
      busy   <= 1'b0;
      act    <= '0;
    end else begin
      dreq_q <= dreq_n;
      if (reg_we) begin
        if (wop) begin
          dme <= reg_wdata[0];
          if (!reg_wdata[1]) nmif <= 1'b0;
          if (!reg_wdata[2]) aef <= 1'b0;
        end else if (widx == 2'd3) begin
          ctl[wch] <= {reg_wdata[8:2], ctl[wch][1] & reg_wdata[1], reg_wdata[0]};
        end else if (!ctl[wch][0]) begin
          case (widx)
            2'd0:    src[wch] <= reg_wdata;
            2'd1:    dst[wch] <= reg_wdata;
            default: cnt[wch] <= reg_wdata;
          endcase
        end
      end
      if (nmi) nmif <= 1'b1;
      if (busy) begin
        if (bus_ack) begin
          busy <= 1'b0;
          if (ctl[act][2]) src[act] <= src[act] + step;
          if (ctl[act][3]) dst[act] <= dst[act] + step;
          cnt[act] <= cnt[act] - 1'b1;
          if (cnt[act] == AW'(1)) ctl[act][1] <= 1'b1;
        end
      end else if (go) begin
        if (bad) aef <= 1'b1;
        else begin
          busy       <= 1'b1;
          act        <= pick;
          pend[pick] <= 1'b0;
        end
      end
      for (int c = 0; c < NCH; c++)
        if (ctl[c][7] && ctl[c][8] && dreq_q[c] && !dreq_n[c]) pend[c] <= 1'b1;
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !bus_ack |=> busy && $stable(act)); // R13
  AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !$past(busy) |-> $past(dme && !nmif && !aef)); // R2
  AST_NMI_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    nmi |=> nmif); // R4
  AST_NO_INTERNAL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    busy && bus_single |-> bus_src[AW-1 -: 4] != IPAGE); // R7

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    AST_CNT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ctl[g][0]) && !$past(busy) |-> $stable(cnt[g])); // R12
  end
endmodule

// File: tb/sim_dma_ctrl.sv
`timescale 1ns/1ps
module sim_dma_ctrl;
  localparam int NCH = 2;
  localparam int AW = 16;
  localparam int CHW = 1;
  localparam int EN = 1, TE = 2, SINC = 4, DINC = 8, SGL = 'h40, EXT = 'h80, EDG = 'h100;

  logic clk = 0, rst_n = 0, nmi = 0, reg_we = 0, bus_ack = 0;
  logic [NCH-1:0] dreq_n = '1;
  logic [CHW+2:0] reg_addr = '0;
  logic [AW-1:0] reg_wdata = '0, reg_rdata, bus_src, bus_dst;
  logic bus_req, bus_single;
  logic [CHW-1:0] bus_ch;
  logic [1:0] bus_size;

  int tests = 0, fails = 0, xfers = 0, lat = 1, wc = 0;
  logic [CHW-1:0] chlog [16];

  dma_ctrl #(.NCH(NCH), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .nmi(nmi), .dreq_n(dreq_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .bus_req(bus_req), .bus_ch(bus_ch), .bus_src(bus_src), .bus_dst(bus_dst),
    .bus_size(bus_size), .bus_single(bus_single), .bus_ack(bus_ack));

  always #2 clk = ~clk;

  always @(negedge clk) begin
    if (!rst_n) begin
      bus_ack = 0; wc = 0;
    end else if (bus_ack) bus_ack = 0;
    else if (bus_req) begin
      wc++;
      if (wc >= lat) begin
        bus_ack = 1; wc = 0;
        if (xfers < 16) chlog[xfers] = bus_ch;
        xfers++;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); reg_we = 1; reg_addr = a[CHW+2:0]; reg_wdata = d[AW-1:0];
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk); reg_addr = a[CHW+2:0]; #1 d = int'(reg_rdata);
  endtask

  task automatic rchk(input string req, input int a, input int exp);
    int d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic wait_x(input int n);
    for (int i = 0; i < 600 && xfers < n; i++) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  task automatic do_reset(input int l);
    rst_n = 0; nmi = 0; dreq_n = '1; reg_we = 0; lat = l;
    repeat (3) @(negedge clk);
    xfers = 0; rst_n = 1;
    @(negedge clk);
  endtask

  task automatic t_reset;
    do_reset(1);
    for (int a = 0; a < 9; a++) rchk("R1 reg", a, 0);
    check("R1 bus_req", int'(bus_req), 0);
  endtask

  task automatic t_basic;
    do_reset(2);
    wr(0, 'h1000); wr(1, 'h2000); wr(2, 3); wr(3, EN | SINC | DINC | 'h10);
    repeat (10) @(negedge clk);
    check("R2 no master", xfers, 0);
    wr(8, 1);
    wait_x(3);
    check("R3 xfers", xfers, 3);
    rchk("R3 src", 0, 'h1006);
    rchk("R3 dst", 1, 'h2006);
    rchk("R3 cnt", 2, 0);
    rchk("R3 ctl", 3, EN | TE | SINC | DINC | 'h10);
    wr(0, 'h5555); wr(2, 7);
    rchk("R12 src locked", 0, 'h1006);
    rchk("R12 cnt locked", 2, 0);
  endtask

  task automatic t_dme_first;
    do_reset(1);
    wr(8, 1); wr(0, 'h40); wr(1, 'h80); wr(2, 2); wr(3, EN);
    wait_x(2);
    check("R2 dme first", xfers, 2);
    rchk("R3 src fixed", 0, 'h40);
    rchk("R3 dst fixed", 1, 'h80);
  endtask

  task automatic t_nmi_idle;
    do_reset(1);
    @(negedge clk); nmi = 1; @(negedge clk); nmi = 0;
    rchk("R4 flag idle", 8, 2);
    wr(2, 4); wr(3, EN); wr(8, 3);
    repeat (20) @(negedge clk);
    check("R4 blocked", xfers, 0);
    rchk("R6 cnt kept", 2, 4);
    wr(8, 1);
    rchk("R4 cleared", 8, 1);
    wait_x(4);
    check("R4 resumed", xfers, 4);
  endtask

  task automatic t_nmi_mid;
    int x;
    do_reset(3);
    wr(0, 'h100); wr(1, 'h200); wr(2, 5); wr(3, EN | SINC | DINC | 'h20); wr(8, 1);
    for (int i = 0; i < 200 && xfers < 2; i++) @(negedge clk);
    @(negedge clk); nmi = 1; @(negedge clk); nmi = 0;
    repeat (20) @(negedge clk);
    x = xfers;
    check("R5 stopped early", int'(x >= 2 && x < 5), 1);
    rchk("R5 cnt remain", 2, 5 - x);
    rchk("R5 next src", 0, 'h100 + 4 * x);
    rchk("R5 next dst", 1, 'h200 + 4 * x);
    rchk("R5 en/end", 3, EN | SINC | DINC | 'h20);
    repeat (20) @(negedge clk);
    check("R5 frozen", xfers, x);
    wr(8, 1);
    wait_x(5);
    check("R5 finish", xfers, 5);
  endtask

  task automatic t_single;
    do_reset(1);
    wr(0, 'h3000); wr(2, 3); wr(3, EN | EXT);
    wr(4, 'hF010); wr(6, 2); wr(7, EN | SGL);
    wr(8, 1);
    repeat (5) @(negedge clk);
    rchk("R7 ae flag", 8, 5);
    dreq_n[0] = 0;
    repeat (20) @(negedge clk);
    check("R7 all halted", xfers, 0);
    rchk("R7 ch0 cnt", 2, 3);
  endtask

  task automatic t_level;
    do_reset(1);
    wr(0, 'h10); wr(2, 3); wr(3, EN | EXT); wr(8, 1);
    repeat (15) @(negedge clk);
    check("R11 high idle", xfers, 0);
    dreq_n[0] = 0;
    wait_x(3);
    check("R11 low runs", xfers, 3);
  endtask

  task automatic t_misalign;
    do_reset(1);
    wr(0, 'h102); wr(1, 'h200); wr(2, 1); wr(3, EN | 'h20); wr(8, 1);
    repeat (10) @(negedge clk);
    rchk("R8 ae flag", 8, 5);
    check("R8 no cycle", xfers, 0);
  endtask

  task automatic t_dme_stop;
    do_reset(6);
    wr(2, 5); wr(3, EN); wr(8, 1);
    for (int i = 0; i < 100 && !bus_req; i++) @(negedge clk);
    wr(8, 0);
    check("R9 req held", int'(bus_req), 1);
    repeat (30) @(negedge clk);
    check("R9 one xfer", xfers, 1);
    rchk("R9 cnt", 2, 4);
    check("R9 idle", int'(bus_req), 0);
  endtask

  task automatic t_edge;
    do_reset(1);
    wr(2, 3); wr(3, EN | EXT | EDG); wr(8, 1);
    repeat (10) @(negedge clk);
    check("R10 no edge", xfers, 0);
    dreq_n[0] = 0; repeat (3) @(negedge clk); dreq_n[0] = 1;
    repeat (15) @(negedge clk);
    check("R10 one edge", xfers, 1);
    dreq_n[0] = 0; repeat (3) @(negedge clk); dreq_n[0] = 1;
    repeat (15) @(negedge clk);
    check("R10 two edges", xfers, 2);
  endtask

  task automatic t_prio;
    do_reset(1);
    wr(2, 2); wr(3, EN); wr(6, 2); wr(7, EN); wr(8, 1);
    wait_x(4);
    check("R13 count", xfers, 4);
    check("R13 first", int'(chlog[0]), 0);
    check("R13 second", int'(chlog[1]), 0);
    check("R13 third", int'(chlog[2]), 1);
    check("R13 fourth", int'(chlog[3]), 1);
  endtask

  initial begin
    #(4 * 150000);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_dme_first();
    t_nmi_idle();
    t_nmi_mid();
    t_single();
    t_level();
    t_misalign();
    t_dme_stop();
    t_edge();
    t_prio();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule